// File: doc/BRIEF.md
# Real-Time Clock Read-Ready Window

This block sits beside the time-of-day counters of a real-time clock. It counts ticks of the 32768 Hz time base in a prescaler and issues a one-second update strobe each time the prescaler wraps. Around that wrap it opens a keep-out window. The window covers a set number of prescaler counts on each side of the update. Inside the window a `ready` status bit is low. Outside it the bit is high. A processor on an unrelated clock polls `ready`, or waits for the interrupt, before it reads the time registers.

A sticky flag records each rising edge of `ready`. When the flag is set, software has almost a whole second before the next keep-out window opens. The flag drives an interrupt line only while the enable input is high. The flag is cleared by a software clear or by a one-cycle service acknowledge. If a new rising edge arrives in the same cycle as a clear, the flag is set.

While a time register write is in progress, `wr_hold` stops the clock. It holds the prescaler at zero, so the first update after the write comes one full prescaler period after release.

Top module: `rtc_rdy_window`

## Requirements
- R1: The prescaler `presc_cnt` advances by one on each cycle with `tick` high, wraps modulo 2^PRESC_W, and holds its value on cycles with `tick` low.
- R2: `sec_strobe` is high for exactly the one cycle after a tick that moves the prescaler from its maximum value to zero, and low at all other times.
- R3: `ready` is low while `presc_cnt` is below HALF_WIN or at least 2^PRESC_W - HALF_WIN, and high otherwise. It always follows the `presc_cnt` value shown in the same cycle.
- R4: While `wr_hold` is high, the prescaler is forced to zero, ticks are ignored and no strobe is produced. After release, the next strobe appears after exactly 2^PRESC_W ticks.
- R5: `rdy_flag` becomes high in the cycle after `ready` rises, and then stays high until it is cleared.
- R6: `irq` equals `rdy_flag` while `irq_en` is high and is low while `irq_en` is low. `irq_en` never changes `rdy_flag`.
- R7: A one-cycle `sw_clr` or `svc_ack` clears `rdy_flag` in the following cycle.
- R8: When a clear (`sw_clr` or `svc_ack`) falls in the same cycle as a rising edge of `ready`, `rdy_flag` is high in the next cycle (set wins).
- R9: After reset, `presc_cnt` is 0, and `sec_strobe`, `ready`, `rdy_flag` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Enable for one 32768 Hz time-base count |
| wr_hold | input | 1 | Time register write in progress: stop and zero the prescaler |
| irq_en | input | 1 | Interrupt enable for the ready flag |
| sw_clr | input | 1 | Software clear of the ready flag |
| svc_ack | input | 1 | One-cycle interrupt service acknowledge |
| presc_cnt | output | PRESC_W | Current prescaler value |
| sec_strobe | output | 1 | One-second update pulse |
| ready | output | 1 | High outside the keep-out window |
| rdy_flag | output | 1 | Sticky flag set on each rising edge of ready |
| irq | output | 1 | Interrupt request: flag gated by enable |

## Verification
A wrong prescaler value shows on `presc_cnt` in the same cycle. Within one wrap period it also shows on `ready` and `sec_strobe`, as a window that is misplaced or has the wrong width. A lost or stale copy of the previous `ready` value shows up as a missing or doubled `rdy_flag` set. This appears one cycle after the window closes, so each simulated second of the sweep checks it once. A flag register that misorders set against clear shows as a wrong `rdy_flag` or `irq` one cycle after the acknowledge.

// File: rtl/rtc_rdy_pkg.sv
package rtc_rdy_pkg;

    // Default geometry: 15-bit prescaler at 32768 Hz, 64 counts each side of the wrap
    localparam int DEF_PRESC_W  = 15;
    localparam int DEF_HALF_WIN = 64;

    typedef struct packed {
        logic ready_prev;
        logic flag;
    } flag_state_t;

    typedef struct packed {
        logic ready;
    } win_state_t;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESC_W = rtc_rdy_pkg::DEF_PRESC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               hold,
    output logic [PRESC_W-1:0] cnt_d_o,
    output logic [PRESC_W-1:0] cnt_q_o,
    output logic               strobe_o
);
    localparam logic [PRESC_W-1:0] CNT_MAX = {PRESC_W{1'b1}};

    typedef struct packed {
        logic [PRESC_W-1:0] cnt;
        logic               strobe;
    } presc_state_t;

    presc_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (hold) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt    = st_q.cnt + 1'b1;
            st_d.strobe = (st_q.cnt == CNT_MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_d_o  = st_d.cnt;
    assign cnt_q_o  = st_q.cnt;
    assign strobe_o = st_q.strobe;

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt_q_o == '0 && !strobe_o)); // R4
    AST_STROBE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (cnt_q_o == '0)); // R2
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o); // R2
    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hold) |=> $stable(cnt_q_o)); // R1
endmodule

// File: rtl/rtc_keepout.sv
module rtc_keepout #(
    parameter int PRESC_W  = rtc_rdy_pkg::DEF_PRESC_W,
    parameter int HALF_WIN = rtc_rdy_pkg::DEF_HALF_WIN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] cnt_next,
    input  logic [PRESC_W-1:0] cnt_now,
    output logic               ready_o
);
    import rtc_rdy_pkg::*;

    localparam logic [PRESC_W-1:0] LO_EDGE = PRESC_W'(HALF_WIN);
    localparam logic [PRESC_W-1:0] HI_EDGE = PRESC_W'((1 << PRESC_W) - HALF_WIN);

    win_state_t st_d, st_q;

    // Ready for the next cycle is taken from the next count so it lines up with it
    always_comb begin
        st_d.ready = (cnt_next >= LO_EDGE) && (cnt_next < HI_EDGE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = st_q.ready;

    AST_LOW_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_now == '0) |-> !ready_o); // R3
    AST_LOW_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_now == {PRESC_W{1'b1}}) |-> !ready_o); // R3
endmodule

// File: rtl/rtc_rdy_flag.sv
module rtc_rdy_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic irq_en,
    input  logic sw_clr,
    input  logic svc_ack,
    output logic flag_o,
    output logic irq_o
);
    import rtc_rdy_pkg::*;

    flag_state_t st_d, st_q;
    logic        rise;
    logic        clr;

    always_comb begin
        rise            = ready && !st_q.ready_prev;
        clr             = sw_clr || svc_ack;
        st_d.ready_prev = ready;
        if (rise)     st_d.flag = 1'b1;
        else if (clr) st_d.flag = 1'b0;
        else          st_d.flag = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag && irq_en;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> flag_o); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rise) |=> !flag_o); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr) |=> flag_o); // R5
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !rise) |=> !flag_o); // R5
endmodule

// File: rtl/rtc_rdy_window.sv
module rtc_rdy_window #(
    parameter int PRESC_W  = rtc_rdy_pkg::DEF_PRESC_W,
    parameter int HALF_WIN = rtc_rdy_pkg::DEF_HALF_WIN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_hold,
    input  logic               irq_en,
    input  logic               sw_clr,
    input  logic               svc_ack,
    output logic [PRESC_W-1:0] presc_cnt,
    output logic               sec_strobe,
    output logic               ready,
    output logic               rdy_flag,
    output logic               irq
);
    logic [PRESC_W-1:0] cnt_next;

    rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hold     (wr_hold),
        .cnt_d_o  (cnt_next),
        .cnt_q_o  (presc_cnt),
        .strobe_o (sec_strobe)
    );

    rtc_keepout #(.PRESC_W(PRESC_W), .HALF_WIN(HALF_WIN)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_next (cnt_next),
        .cnt_now  (presc_cnt),
        .ready_o  (ready)
    );

    rtc_rdy_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready   (ready),
        .irq_en  (irq_en),
        .sw_clr  (sw_clr),
        .svc_ack (svc_ack),
        .flag_o  (rdy_flag),
        .irq_o   (irq)
    );

    AST_STROBE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        sec_strobe |-> !ready); // R3
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rdy_flag); // R6
endmodule

// File: tb/rtc_rdy_window_test.sv
module rtc_rdy_window_test;
    localparam int W    = 6;
    localparam int HW   = 4;
    localparam int MODN = 1 << W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, wr_hold = 1'b0, irq_en = 1'b0, sw_clr = 1'b0, svc_ack = 1'b0;
    logic [W-1:0] presc_cnt;
    logic sec_strobe, ready, rdy_flag, irq;

    int tests = 0, fails = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0;
    bit m_strobe = 0, m_ready = 0, m_prev = 0, m_flag = 0;

    always #4 clk = ~clk;

    rtc_rdy_window #(.PRESC_W(W), .HALF_WIN(HW)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_hold(wr_hold), .irq_en(irq_en),
        .sw_clr(sw_clr), .svc_ack(svc_ack), .presc_cnt(presc_cnt), .sec_strobe(sec_strobe),
        .ready(ready), .rdy_flag(rdy_flag), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit win_ready(int c);
        return (c >= HW) && (c < MODN - HW);
    endfunction

    // Drive at negedge, advance one edge, update the model, compare at next negedge
    task automatic step(bit t, bit h, bit en, bit c, bit a);
        bit rise;
        tick = t; wr_hold = h; irq_en = en; sw_clr = c; svc_ack = a;
        @(posedge clk);
        rise = m_ready && !m_prev;
        if (rise) m_flag = 1;
        else if (c || a) m_flag = 0;
        m_prev = m_ready;
        m_strobe = 0;
        if (h) m_cnt = 0;
        else if (t) begin
            m_strobe = (m_cnt == MODN - 1);
            m_cnt = (m_cnt + 1) % MODN;
        end
        m_ready = win_ready(m_cnt);
        @(negedge clk);
        chk("R1 count", int'(presc_cnt), m_cnt);
        chk("R2 strobe", int'(sec_strobe), int'(m_strobe));
        chk("R3 ready", int'(ready), int'(m_ready));
        chk("R5 flag", int'(rdy_flag), int'(m_flag));
        chk("R6 irq", int'(irq), int'(m_flag && en));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 cnt", int'(presc_cnt), 0);
        chk("R9 strobe", int'(sec_strobe), 0);
        chk("R9 ready", int'(ready), 0);
        chk("R9 flag", int'(rdy_flag), 0);
        chk("R9 irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Phase A: continuous ticks across three wraps
        for (int i = 0; i < 3 * MODN + 10; i++) step(1, 0, 1, 0, 0);

        // Phase B: gapped ticks, toggling enable, software clears while flag set
        for (int i = 0; i < 3 * MODN; i++) begin
            bit cl = m_flag && (i % 7 == 0) && !(m_ready && !m_prev);
            bit was = m_flag;
            step(i % 3 != 0, 0, i[1], cl, 0);
            if (cl && was) chk("R7 sw_clr clears", int'(rdy_flag), 0);
        end

        // Phase C: write hold mid-second, then count to the next strobe
        for (int i = 0; i < 20; i++) step(1, 0, 1, 0, 0);
        for (int i = 0; i < 5; i++) step(1, 1, 1, 0, 0);
        chk("R4 held at zero", int'(presc_cnt), 0);
        chk("R4 not ready while held", int'(ready), 0);
        begin
            int n = 0;
            do begin
                step(1, 0, 1, 0, 0);
                n++;
            end while (!sec_strobe && n < 4 * MODN);
            chk("R4 ticks to first strobe after release", n, MODN);
        end

        // Phase D: acknowledge coinciding with a rising edge, then a plain acknowledge
        begin
            int guard = 0;
            while (!(m_ready && !m_prev) && guard < 4 * MODN) begin
                step(1, 0, 1, 0, m_flag);
                guard++;
            end
            step(1, 0, 1, 0, 1);
            chk("R8 set wins over ack", int'(rdy_flag), 1);
            step(1, 0, 1, 0, 1);
            chk("R7 ack clears", int'(rdy_flag), 0);
            chk("R6 irq low after ack", int'(irq), 0);
        end

        // R6: enable low while flag set leaves the flag alone
        for (int i = 0; i < MODN; i++) step(1, 0, 0, 0, 0);
        chk("R6 flag kept with enable low", int'(rdy_flag), 1);
        chk("R6 irq masked", int'(irq), 0);
        step(1, 0, 1, 0, 0);
        chk("R6 irq follows flag when enabled", int'(irq), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule